// File: doc/BRIEF.md
# Cyclic Code Coprocessor Control and Phase Sequencer

This block holds the 24-bit control/status word of a shift-based cyclic code coprocessor and sequences its processing. A host writes the word through a single-cycle write port and can always read it back combinationally. The block has three operating conditions:

- Off: the enable bit is clear. The sequencer and its status are held at their reset values, and the control fields keep what was written.
- Idle: enabled, but the go bit is clear. Everything is frozen and the host may reconfigure.
- Busy: enabled and go set.

While busy, the block walks through an input phase, a run phase and an output phase. It drives a shift-enable and a freeze line to an external shifter and FIFO.

The go bit is set by software and cleared by hardware. In full-pass mode it clears when the output phase completes. In step mode it clears after one single shift. The host may also clear go at any time to abort. Phase advances are driven by done indications from the datapath.

Top module: `ccx_ctrl_seq`

## Requirements
- R1: After reset, `host_rdata` reads 0, `phase_st` is 0, `freeze` is 1 and `shift_en` is 0.
- R2: The word layout is as follows. Bit 0 is enable. Bit 1 is go. Bits 5:4 are the mode, where 01 is step mode and all other values are full-pass. Bits 15:12 are a general control field. Bits 23:22 are the read-only phase status, encoded idle=0, input=1, run=2, output=3. Every other bit reads 0, and writing it has no effect.
- R3: Writing enable=0 returns the block to idle and clears go in the same edge, while the mode and control fields keep their values.
- R4: A write with go=1 is ignored while the stored enable bit is 0; go reads back 0.
- R5: While the phase is not idle, `shift_en` is 1 and `freeze` is 0. While the phase is idle, `shift_en` is 0 and `freeze` is 1. In full-pass mode, a go write enters the input phase. `in_done` then advances the phase to run, and `run_done` advances it to output.
- R6: In the output phase, `out_done` returns the block to idle and clears go at the same edge.
- R7: In step mode, a go write produces exactly one cycle of `shift_en` (status run), then idle with go cleared. A go=1 write during that shift cycle does not extend it.
- R8: A host write of go=0 while busy returns the block to idle at that write's edge.
- R9: The mode field is written only while the stored enable bit is 0.
- R10: The control field at bits 15:12 accepts writes while idle or off, and ignores writes while busy.
- R11: Done inputs that do not match the current phase have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the control/status word |
| host_wdata | input | 24 | Write data |
| host_rdata | output | 24 | Read-back of the control/status word |
| in_done | input | 1 | Datapath reports the input phase complete |
| run_done | input | 1 | Datapath reports the run phase complete |
| out_done | input | 1 | Datapath reports the output phase complete |
| shift_en | output | 1 | Shifter advance enable |
| freeze | output | 1 | Hold datapath and FIFO contents |
| phase_st | output | 2 | Current phase (idle=0, input=1, run=2, output=3) |

## Verification
The assertions take for granted that the mode field stays constant while the block is enabled. They also take for granted that done strobes are meaningful only in their own phase. The design enforces the first of these, and the bench deliberately violates the second to show it has no effect. Host writes are single-cycle strobes driven at the falling edge, with full 24-bit words that always carry the intended enable value. Done pulses are held for one cycle, so the phase machine sees each one at exactly one rising edge.

// File: rtl/ccx_pkg.sv
package ccx_pkg;
  localparam int unsigned WORD_W   = 24;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned GO_BIT   = 1;
  localparam int unsigned MODE_LSB = 4;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned AUX_LSB  = 12;
  localparam int unsigned AUX_W    = 4;
  localparam int unsigned PH_LSB   = 22;
  localparam int unsigned PH_W     = 2;
  localparam logic [MODE_W-1:0] MODE_STEP = 2'b01;

  typedef enum logic [PH_W-1:0] {
    PH_IDLE = 2'd0,
    PH_IN   = 2'd1,
    PH_RUN  = 2'd2,
    PH_OUT  = 2'd3
  } phase_e;
endpackage

// File: rtl/ccx_csr_regs.sv
module ccx_csr_regs
  import ccx_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned AW = AUX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic [PH_W-1:0]   phase,
  input  logic              clr_go,
  output logic              en_q,
  output logic              go_q,
  output logic              en_nx,
  output logic              go_nx,
  output logic [MODE_W-1:0] mode_q,
  output logic [AW-1:0]     aux_q,
  output logic [W-1:0]      rd_data
);
  logic busy;
  assign busy = (phase != PH_IDLE);

  // Next enable and go values; they feed the phase machine so that the
  // reaction to a write happens at the same edge as the write.
  always_comb begin
    en_nx = wr_en ? wr_data[EN_BIT] : en_q;
    if (!en_nx)                              go_nx = 1'b0;
    else if (wr_en && !wr_data[GO_BIT])      go_nx = 1'b0;
    else if (clr_go)                         go_nx = 1'b0;
    else if (wr_en && wr_data[GO_BIT] && en_q) go_nx = 1'b1;
    else                                     go_nx = go_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      go_q   <= 1'b0;
      mode_q <= '0;
      aux_q  <= '0;
    end else begin
      en_q <= en_nx;
      go_q <= go_nx;
      if (wr_en && !en_q) mode_q <= wr_data[MODE_LSB +: MODE_W];
      if (wr_en && !busy) aux_q  <= wr_data[AUX_LSB +: AW];
    end
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[EN_BIT]             = en_q;
    rd_data[GO_BIT]             = go_q;
    rd_data[MODE_LSB +: MODE_W] = mode_q;
    rd_data[AUX_LSB +: AW]      = aux_q;
    rd_data[PH_LSB +: PH_W]     = phase;
  end

  // R4: go cannot be set while the stored enable bit is clear
  a_r4_go_needs_en: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !en_q) |=> !go_q);

  // R9: mode holds while enabled
  a_r9_mode_locked: assert property (@(posedge clk) disable iff (rst)
    en_q |=> $stable(mode_q));

  // R10: control field holds while busy
  a_r10_aux_locked: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(aux_q));
endmodule

// File: rtl/ccx_phase_fsm.sv
module ccx_phase_fsm
  import ccx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en_nx,
  input  logic            go_nx,
  input  logic            step,
  input  logic            in_done,
  input  logic            run_done,
  input  logic            out_done,
  output logic [PH_W-1:0] phase_o,
  output logic            clr_go,
  output logic            shift_en_q,
  output logic            freeze_q
);
  phase_e phase_q, phase_d;

  // Auto-clear depends only on state and done inputs (no loop through go).
  assign clr_go = (phase_q == PH_OUT && out_done) ||
                  (phase_q == PH_RUN && step);

  always_comb begin
    phase_d = phase_q;
    if (!(en_nx && go_nx)) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: phase_d = step ? PH_RUN : PH_IN;
        PH_IN:   if (in_done)  phase_d = PH_RUN;
        PH_RUN:  if (run_done) phase_d = PH_OUT;
        PH_OUT:  if (out_done) phase_d = PH_IDLE;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      shift_en_q <= 1'b0;
      freeze_q   <= 1'b1;
    end else begin
      phase_q    <= phase_d;
      shift_en_q <= (phase_d != PH_IDLE);
      freeze_q   <= (phase_d == PH_IDLE);
    end
  end

  assign phase_o = phase_q;

  // R5: exactly one of shift and freeze is active
  a_r5_shift_xor_freeze: assert property (@(posedge clk) disable iff (rst)
    $onehot({shift_en_q, freeze_q}));

  // R6: completion of output phase returns to idle
  a_r6_out_to_idle: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_OUT && out_done) |=> phase_q == PH_IDLE);

  // R7: a step lasts one cycle
  a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
    (step && phase_q == PH_RUN) |=> phase_q == PH_IDLE);

  // R11: input phase waits for its own done
  a_r11_in_waits: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IN && !in_done && en_nx && go_nx) |=> phase_q == PH_IN);
endmodule

// File: rtl/ccx_ctrl_seq.sv
module ccx_ctrl_seq
  import ccx_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned AW = AUX_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  input  logic         in_done,
  input  logic         run_done,
  input  logic         out_done,
  output logic         shift_en,
  output logic         freeze,
  output logic [1:0]   phase_st
);
  logic              en_q, go_q, en_nx, go_nx, clr_go;
  logic [MODE_W-1:0] mode_q;
  logic [AW-1:0]     aux_q;
  logic [PH_W-1:0]   phase;

  ccx_csr_regs #(.W(W), .AW(AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (host_wr),
    .wr_data (host_wdata),
    .phase   (phase),
    .clr_go  (clr_go),
    .en_q    (en_q),
    .go_q    (go_q),
    .en_nx   (en_nx),
    .go_nx   (go_nx),
    .mode_q  (mode_q),
    .aux_q   (aux_q),
    .rd_data (host_rdata)
  );

  ccx_phase_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en_nx      (en_nx),
    .go_nx      (go_nx),
    .step       (mode_q == MODE_STEP),
    .in_done    (in_done),
    .run_done   (run_done),
    .out_done   (out_done),
    .phase_o    (phase),
    .clr_go     (clr_go),
    .shift_en_q (shift_en),
    .freeze_q   (freeze)
  );

  assign phase_st = phase;

  // R3: disabled block is always idle
  a_r3_off_is_idle: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> phase == PH_IDLE);

  // R8: host write of go=0 stops processing at that edge
  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_wdata[GO_BIT]) |=> phase == PH_IDLE);

  // R5: busy implies enable and go both set
  a_r5_busy_needs_go: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> (en_q && go_q));
endmodule

// File: tb/test_ccx_ctrl_seq.sv
module test_ccx_ctrl_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [23:0] host_wdata = '0;
  logic [23:0] host_rdata;
  logic        in_done = 1'b0, run_done = 1'b0, out_done = 1'b0;
  logic        shift_en, freeze;
  logic [1:0]  phase_st;

  int errors = 0;
  int checks = 0;
  int shifts = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccx_ctrl_seq i_ccx_ctrl_seq (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .in_done(in_done), .run_done(run_done),
    .out_done(out_done), .shift_en(shift_en), .freeze(freeze),
    .phase_st(phase_st)
  );

  always @(negedge clk) if (shift_en) shifts++;

  task automatic chk(input logic [23:0] act, input logic [23:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] d);
    @(negedge clk); host_wr = 1'b1; host_wdata = d;
    @(negedge clk); host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    in_done = (which == 0); run_done = (which == 1); out_done = (which == 2);
    @(negedge clk);
    in_done = 1'b0; run_done = 1'b0; out_done = 1'b0;
  endtask

  task automatic t_reset;
    chk(host_rdata, 24'h0, "R1 rdata");
    chk({22'd0, phase_st}, 24'd0, "R1 phase");
    chk({23'd0, freeze}, 24'd1, "R1 freeze");
    chk({23'd0, shift_en}, 24'd0, "R1 shift_en");
  endtask

  task automatic t_fields;
    wr(24'h000002);
    chk(host_rdata, 24'h000000, "R4 go without enable");
    wr(24'hFFFFFF);
    chk(host_rdata, 24'h00F031, "R2 field layout and reserved bits");
    chk({22'd0, phase_st}, 24'd0, "R4 no start from off");
    wr(24'h000001);
    chk(host_rdata, 24'h000031, "R9 mode kept, R10 aux written in idle");
    wr(24'h000000);
    chk(host_rdata, 24'h000030, "R3 control kept when disabled");
    wr(24'h000001);
    chk(host_rdata, 24'h000001, "R9 mode written while off");
  endtask

  task automatic t_full_pass;
    wr(24'h000003);
    chk(host_rdata, 24'h400003, "R5 input phase");
    chk({22'd0, shift_en, freeze}, 24'd2, "R5 shift on freeze off");
    pulse(1); pulse(2);
    chk({22'd0, phase_st}, 24'd1, "R11 wrong done ignored in input");
    pulse(0);
    chk(host_rdata, 24'h800003, "R5 run phase");
    wr(24'h00F003);
    chk(host_rdata, 24'h800003, "R10 aux ignored while busy");
    pulse(2);
    chk({22'd0, phase_st}, 24'd2, "R11 out_done ignored in run");
    pulse(1);
    chk({22'd0, phase_st}, 24'd3, "R5 output phase");
    pulse(2);
    chk(host_rdata, 24'h000001, "R6 auto clear after output");
    chk({22'd0, shift_en, freeze}, 24'd1, "R6 frozen again");
  endtask

  task automatic t_abort;
    wr(24'h000003);
    chk({22'd0, phase_st}, 24'd1, "R8 started");
    wr(24'h000001);
    chk(host_rdata, 24'h000001, "R8 abort to idle");
    chk({23'd0, shift_en}, 24'd0, "R8 shift stopped");
    wr(24'h000003);
    wr(24'h000000);
    chk(host_rdata, 24'h000000, "R3 disable while busy");
    wr(24'h000011);
    chk(host_rdata, 24'h000011, "R9 step mode loaded while off");
  endtask

  task automatic t_step;
    shifts = 0;
    wr(24'h000013);
    chk(host_rdata, 24'h800013, "R7 step shift cycle");
    chk({23'd0, shift_en}, 24'd1, "R7 shift asserted");
    @(negedge clk);
    chk(host_rdata, 24'h000011, "R7 go cleared after one shift");
    repeat (3) @(negedge clk);
    chk(shifts, 1, "R7 single shift count");
    shifts = 0;
    @(negedge clk); host_wr = 1'b1; host_wdata = 24'h000013;
    @(negedge clk);
    @(negedge clk); host_wr = 1'b0; host_wdata = '0;
    chk(host_rdata, 24'h000011, "R7 rewrite during shift does not extend");
    repeat (3) @(negedge clk);
    chk(shifts, 1, "R7 one shift despite rewrite");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fields();
    t_full_pass();
    t_abort();
    t_step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule